// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a 64-bit main counter that lives outside the channel. Each cycle, the surrounding logic tells it whether the counter took a step. The channel holds the comparator value, the period used for periodic reloads and a small mode word. When the counter reaches the programmed point in time, it emits a fire strobe one cycle wide. Interrupt status, routing and the counter itself belong to the consumers and producers around it.

Software programs the channel through one write port. A select code picks either the mode word or one of the two comparator halves. The channel runs in one-shot or periodic mode, and compares either all 64 bits or only the low 32 bits. In periodic mode a self-clearing set-value bit decides whether a comparator write also moves the comparator or only changes the period. In 32-bit one-shot mode the channel also fires each time the low half of the counter wraps to zero.

Top module: `evtc_channel`

## Requirements
- R1: After reset the comparator and the period read all ones, the fire strobe is 0, and the mode word reads 0x30: bit 4 (periodic capable) and bit 5 (64-bit capable) are read-only ones.
- R2: A write with select 0 loads the mode word from the data. Bit 0 selects periodic mode, bit 1 selects 32-bit mode and bit 2 is set-value. The other writable bits read 0. Select 1 writes the comparator low half, select 2 writes the high half, and select 3 has no effect.
- R3: A counter step is a cycle with tick=1 and enable=1. If the counter equals the comparator in that cycle, fire is 1 for exactly the following cycle.
- R4: No fire occurs while enable is 0 or while tick is 0, whatever the counter value.
- R5: In 64-bit mode all 64 bits are compared, so a comparator of 0 is matched when the counter wraps from all ones to 0.
- R6: In 32-bit mode only the low 32 bits of counter and comparator are compared.
- R7: In periodic mode a match adds the period to the comparator. In 32-bit mode the sum wraps modulo 2^32 with the upper half kept 0. A period of zero leaves the comparator unchanged.
- R8: In periodic mode a comparator write always loads that half of the period. It loads the comparator half only when set-value is 1. Set-value clears after every accepted comparator write.
- R9: In one-shot mode a comparator write loads that comparator half and leaves the period unchanged.
- R10: In 32-bit mode a high-half write changes nothing: the comparator, the period and set-value all keep their values.
- R11: A mode write with bit 1 set clears the upper 32 bits of the comparator and of the period.
- R12: In 32-bit one-shot mode a counter step whose low 32 bits are zero fires. This does not happen in periodic or 64-bit mode.
- R13: When a counter step matches in the same cycle as a comparator write, fire still occurs and the advance uses the old period. If the write loads the comparator, the written value replaces the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global timer enable |
| tick | input | 1 | Main counter stepped this cycle |
| count | input | 64 | Current main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 comparator low, 2 comparator high |
| wr_data | input | 32 | Write data |
| fire | output | 1 | Single-cycle fire strobe |
| cmp_q | output | 64 | Current comparator value |
| period_q | output | 64 | Current period value |
| cfg_q | output | 8 | Mode word including capability bits |

## Verification
Software can write a comparator half in the very cycle when a counter step matches and a periodic advance is due. The bench provokes this collision twice by driving a matching tick together with a low-half write. The first time set-value is 0, so only the period changes and the comparator must move by the old period. The second time set-value is 1, so the written value must win over the advance. In both cases the fire strobe, the comparator and the period are judged on the following cycle.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int CFG_W       = 8;
    localparam int CFG_PERIODIC = 0;
    localparam int CFG_W32      = 1;
    localparam int CFG_SETVAL   = 2;
    localparam int CFG_CAP_PER  = 4;
    localparam int CFG_CAP_64   = 5;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic setval;
        logic w32;
        logic periodic;
    } chan_mode_t;

    typedef struct packed {
        logic cmp_hit;
        logic wrap_hit;
    } hit_t;

    function automatic logic [CFG_W-1:0] cfg_word(chan_mode_t m);
        logic [CFG_W-1:0] w;
        w = '0;
        w[CFG_PERIODIC] = m.periodic;
        w[CFG_W32]      = m.w32;
        w[CFG_SETVAL]   = m.setval;
        w[CFG_CAP_PER]  = 1'b1;
        w[CFG_CAP_64]   = 1'b1;
        return w;
    endfunction

    function automatic chan_mode_t cfg_decode(logic [CFG_W-1:0] d);
        chan_mode_t m;
        m.periodic = d[CFG_PERIODIC];
        m.w32      = d[CFG_W32];
        m.setval   = d[CFG_SETVAL];
        return m;
    endfunction

endpackage

// File: rtl/evtc_cfg_reg.sv
module evtc_cfg_reg
    import evtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             setval_clr,
    output chan_mode_t       mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (cfg_wr) begin
            mode <= cfg_decode(cfg_data);
        end else if (setval_clr) begin
            mode.setval <= 1'b0;
        end
    end

endmodule

// File: rtl/evtc_match.sv
module evtc_match
    import evtc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  chan_mode_t       mode,
    input  logic             active,
    output hit_t             hits
);

    localparam int HALF_W = CNT_W / 2;

    logic lo_eq;
    logic hi_eq;
    logic lo_zero;

    assign lo_eq   = (count[HALF_W-1:0] == cmp[HALF_W-1:0]);
    assign hi_eq   = (count[CNT_W-1:HALF_W] == cmp[CNT_W-1:HALF_W]);
    assign lo_zero = (count[HALF_W-1:0] == '0);

    always_comb begin
        hits.cmp_hit  = active & lo_eq & (mode.w32 | hi_eq);
        hits.wrap_hit = active & mode.w32 & ~mode.periodic & lo_zero;
    end

endmodule

// File: rtl/evtc_value_regs.sv
module evtc_value_regs
    import evtc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_mode_t        mode,
    input  hit_t              hits,
    input  logic              wr_en,
    input  wsel_e             wsel,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic              trunc,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [CNT_W-1:0]  period_q,
    output logic              setval_clr
);

    localparam int HALF_W = CNT_W / 2;

    logic              wr_lo, wr_hi;
    logic              cmp_wr_lo, cmp_wr_hi;
    logic              per_wr_lo, per_wr_hi;
    logic              per_nz, do_adv;
    logic [HALF_W-1:0] adv_lo;
    logic [CNT_W-1:0]  adv_full, adv;
    logic [CNT_W-1:0]  cmp_n, per_n;

    assign wr_lo     = wr_en & (wsel == SEL_LO);
    assign wr_hi     = wr_en & (wsel == SEL_HI) & ~mode.w32;
    assign cmp_wr_lo = wr_lo & (~mode.periodic | mode.setval);
    assign cmp_wr_hi = wr_hi & (~mode.periodic | mode.setval);
    assign per_wr_lo = wr_lo & mode.periodic;
    assign per_wr_hi = wr_hi & mode.periodic;
    assign setval_clr = wr_lo | wr_hi;

    assign adv_lo   = cmp_q[HALF_W-1:0] + period_q[HALF_W-1:0];
    assign adv_full = cmp_q + period_q;
    assign per_nz   = mode.w32 ? (|period_q[HALF_W-1:0]) : (|period_q);
    assign do_adv   = hits.cmp_hit & mode.periodic & per_nz;

    generate
        if (CNT_W > HALF_W) begin : g_adv
            assign adv = mode.w32 ? {{(CNT_W-HALF_W){1'b0}}, adv_lo} : adv_full;
        end else begin : g_adv_flat
            assign adv = adv_full;
        end
    endgenerate

    always_comb begin
        cmp_n = (do_adv & ~(cmp_wr_lo | cmp_wr_hi)) ? adv : cmp_q;
        per_n = period_q;
        if (cmp_wr_lo) cmp_n[HALF_W-1:0]     = wr_data;
        if (cmp_wr_hi) cmp_n[CNT_W-1:HALF_W] = wr_data;
        if (per_wr_lo) per_n[HALF_W-1:0]     = wr_data;
        if (per_wr_hi) per_n[CNT_W-1:HALF_W] = wr_data;
        if (trunc) begin
            cmp_n[CNT_W-1:HALF_W] = '0;
            per_n[CNT_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= '1;
            period_q <= '1;
        end else begin
            cmp_q    <= cmp_n;
            period_q <= per_n;
        end
    end

endmodule

// File: rtl/evtc_channel.sv
module evtc_channel
    import evtc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glob_en,
    input  logic               tick,
    input  logic [CNT_W-1:0]   count,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic               fire,
    output logic [CNT_W-1:0]   cmp_q,
    output logic [CNT_W-1:0]   period_q,
    output logic [CFG_W-1:0]   cfg_q
);

    localparam int HALF_W = CNT_W / 2;

    chan_mode_t mode;
    hit_t       hits;
    wsel_e      wsel;
    logic       active;
    logic       cfg_wr;
    logic       trunc;
    logic       setval_clr;
    logic       fire_q;

    assign wsel   = wsel_e'(wr_sel);
    assign active = glob_en & tick;
    assign cfg_wr = wr_en & (wsel == SEL_CFG);
    assign trunc  = cfg_wr & wr_data[CFG_W32];

    evtc_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_data   (wr_data[CFG_W-1:0]),
        .setval_clr (setval_clr),
        .mode       (mode)
    );

    evtc_match #(.CNT_W(CNT_W)) u_match (
        .count  (count),
        .cmp    (cmp_q),
        .mode   (mode),
        .active (active),
        .hits   (hits)
    );

    evtc_value_regs #(.CNT_W(CNT_W)) u_vals (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .hits       (hits),
        .wr_en      (wr_en),
        .wsel       (wsel),
        .wr_data    (wr_data),
        .trunc      (trunc),
        .cmp_q      (cmp_q),
        .period_q   (period_q),
        .setval_clr (setval_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) fire_q <= 1'b0;
        else     fire_q <= hits.cmp_hit | hits.wrap_hit;
    end

    assign fire  = fire_q;
    assign cfg_q = cfg_word(mode);

endmodule

// File: rtl/evtc_channel_chk.sv
module evtc_channel_chk #(
    parameter int CNT_W = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               glob_en,
    input logic               tick,
    input logic [CNT_W-1:0]   count,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [CNT_W/2-1:0] wr_data,
    input logic               fire,
    input logic [CNT_W-1:0]   cmp_q,
    input logic [CNT_W-1:0]   period_q,
    input logic [7:0]         cfg_q
);

    localparam int HALF_W = CNT_W / 2;

    a_r1_reset_values: assert property (@(posedge clk)
        $fell(rst) |-> (cmp_q == '1) && (period_q == '1) && (cfg_q == 8'h30) && !fire);

    a_r4_fire_needs_step: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(glob_en && tick));

    a_r3_fire_single: assert property (@(posedge clk) disable iff (rst)
        (glob_en && tick && !cfg_q[1] && count == cmp_q) |=> fire);

    a_r7_periodic_advance: assert property (@(posedge clk) disable iff (rst)
        (glob_en && tick && cfg_q[0] && !cfg_q[1] && count == cmp_q && !wr_en)
        |=> cmp_q == $past(cmp_q) + $past(period_q));

    a_r8_setval_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> !cfg_q[2]);

    a_r10_hi_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && cfg_q[1]) |=> $stable(period_q) && $stable(cfg_q));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_q[1] |-> (cmp_q[CNT_W-1:HALF_W] == '0) && (period_q[CNT_W-1:HALF_W] == '0));

    a_r12_wrap_fire: assert property (@(posedge clk) disable iff (rst)
        (glob_en && tick && cfg_q[1] && !cfg_q[0] && count[HALF_W-1:0] == '0) |=> fire);

endmodule

bind evtc_channel evtc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .glob_en  (glob_en),
    .tick     (tick),
    .count    (count),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .fire     (fire),
    .cmp_q    (cmp_q),
    .period_q (period_q),
    .cfg_q    (cfg_q)
);

// File: tb/evtc_channel_test.sv
`timescale 1ns/1ps
module evtc_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glob_en = 1'b0;
    logic        tick = 1'b0;
    logic [63:0] count = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        fire;
    logic [63:0] cmp_q;
    logic [63:0] period_q;
    logic [7:0]  cfg_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evtc_channel uut (
        .clk(clk), .rst(rst), .glob_en(glob_en), .tick(tick), .count(count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fire(fire), .cmp_q(cmp_q), .period_q(period_q), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    // One clock: drive inputs, let the edge pass, release strobes.
    task automatic cyc(input logic en, input logic tk, input logic [63:0] cnt,
                       input logic we, input logic [1:0] sel, input logic [31:0] d);
        glob_en = en; tick = tk; count = cnt;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cyc(1'b1, 1'b0, count, 1'b1, sel, d);
    endtask

    task automatic step(input logic [63:0] cnt);
        cyc(1'b1, 1'b1, cnt, 1'b0, 2'd3, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 cmp", cmp_q, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 period", period_q, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 cfg", {56'd0, cfg_q}, 64'h30);
        chk("R1 fire", {63'd0, fire}, 64'd0);
    endtask

    task automatic t_oneshot64;
        wr(2'd0, 32'h0);
        chk("R2 cfg one-shot", {56'd0, cfg_q}, 64'h30);
        wr(2'd1, 32'h100);
        chk("R9 lo load", cmp_q, 64'hFFFF_FFFF_0000_0100);
        wr(2'd2, 32'h1);
        chk("R9 hi load", cmp_q, 64'h1_0000_0100);
        chk("R9 period kept", period_q, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd3, 32'hDEAD);
        chk("R2 sel3 no effect", cmp_q, 64'h1_0000_0100);
        step(64'h1_0000_00FF);
        chk("R3 no match", {63'd0, fire}, 64'd0);
        step(64'h1_0000_0100);
        chk("R3 match fires", {63'd0, fire}, 64'd1);
        step(64'h1_0000_0101);
        chk("R3 single cycle", {63'd0, fire}, 64'd0);
        chk("R9 one-shot cmp kept", cmp_q, 64'h1_0000_0100);
        step(64'h2_0000_0100);
        chk("R6 64-bit needs upper", {63'd0, fire}, 64'd0);
    endtask

    task automatic t_gating;
        cyc(1'b0, 1'b1, 64'h1_0000_0100, 1'b0, 2'd3, 32'd0);
        chk("R4 enable low", {63'd0, fire}, 64'd0);
        cyc(1'b1, 1'b0, 64'h1_0000_0100, 1'b0, 2'd3, 32'd0);
        chk("R4 no tick", {63'd0, fire}, 64'd0);
    endtask

    task automatic t_periodic64;
        wr(2'd0, 32'h5);
        chk("R2 cfg periodic setval", {56'd0, cfg_q}, 64'h35);
        wr(2'd2, 32'h0);
        chk("R8 setval clears", {56'd0, cfg_q}, 64'h31);
        chk("R8 hi with setval", cmp_q, 64'h0000_0000_0000_0100);
        wr(2'd0, 32'h5);
        wr(2'd1, 32'h10);
        chk("R8 cmp loaded", cmp_q, 64'h10);
        chk("R8 period loaded", period_q, 64'h10);
        step(64'h10);
        chk("R3 periodic fire", {63'd0, fire}, 64'd1);
        chk("R7 advance 1", cmp_q, 64'h20);
        step(64'h20);
        chk("R7 advance 2", cmp_q, 64'h30);
        wr(2'd1, 32'h8);
        chk("R8 period only", period_q, 64'h8);
        chk("R8 cmp kept", cmp_q, 64'h30);
        wr(2'd1, 32'h0);
        step(64'h30);
        chk("R7 zero period fires", {63'd0, fire}, 64'd1);
        chk("R7 zero period no advance", cmp_q, 64'h30);
    endtask

    task automatic t_wrap64;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        chk("R9 cmp zero", cmp_q, 64'h0);
        step(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 before wrap", {63'd0, fire}, 64'd0);
        step(64'h0);
        chk("R5 match on wrap", {63'd0, fire}, 64'd1);
    endtask

    task automatic t_mode32;
        wr(2'd0, 32'h5);
        wr(2'd2, 32'hABCD);
        wr(2'd0, 32'h5);
        wr(2'd1, 32'h1234);
        chk("R8 wide cmp", cmp_q, 64'hABCD_0000_1234);
        wr(2'd0, 32'h3);
        chk("R11 cmp truncated", cmp_q, 64'h1234);
        chk("R11 period truncated", period_q, 64'h1234);
        wr(2'd0, 32'h7);
        wr(2'd2, 32'h5555);
        chk("R10 cmp kept", cmp_q, 64'h1234);
        chk("R10 period kept", period_q, 64'h1234);
        chk("R10 setval kept", {56'd0, cfg_q}, 64'h37);
        step(64'h7_0000_1234);
        chk("R6 low-half match", {63'd0, fire}, 64'd1);
        chk("R7 32-bit advance", cmp_q, 64'h2468);
        wr(2'd1, 32'hFFFF_FFF0);
        chk("R8 32-bit load", cmp_q, 64'hFFFF_FFF0);
        step(64'h9_FFFF_FFF0);
        chk("R7 32-bit sum wraps", cmp_q, 64'hFFFF_FFE0);
    endtask

    task automatic t_wrap32;
        wr(2'd0, 32'h2);
        wr(2'd1, 32'h500);
        chk("R9 32 one-shot load", cmp_q, 64'h500);
        step(64'h2_0000_0000);
        chk("R12 wrap fires", {63'd0, fire}, 64'd1);
        step(64'h2_0000_0001);
        chk("R12 after wrap", {63'd0, fire}, 64'd0);
        step(64'h3_0000_0500);
        chk("R12 compare still fires", {63'd0, fire}, 64'd1);
        wr(2'd0, 32'h3);
        step(64'h4_0000_0000);
        chk("R12 not in periodic", {63'd0, fire}, 64'd0);
        wr(2'd0, 32'h0);
        step(64'h4_0000_0000);
        chk("R12 not in 64-bit", {63'd0, fire}, 64'd0);
    endtask

    task automatic t_collision;
        wr(2'd0, 32'h5);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h5);
        wr(2'd1, 32'h100);
        wr(2'd1, 32'h40);
        chk("R8 setup period", period_q, 64'h40);
        cyc(1'b1, 1'b1, 64'h100, 1'b1, 2'd1, 32'h80);
        chk("R13 fire with write", {63'd0, fire}, 64'd1);
        chk("R13 advance old period", cmp_q, 64'h140);
        chk("R13 period written", period_q, 64'h80);
        wr(2'd0, 32'h5);
        cyc(1'b1, 1'b1, 64'h140, 1'b1, 2'd1, 32'h300);
        chk("R13 fire with load", {63'd0, fire}, 64'd1);
        chk("R13 write beats advance", cmp_q, 64'h300);
        chk("R13 period loaded", period_q, 64'h300);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_oneshot64();
        t_gating();
        t_periodic64();
        t_wrap64();
        t_mode32();
        t_wrap32();
        t_collision();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule